// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 31 peripheral interrupt requests into a pending register, gates them with a mask, and drives one combined interrupt line to the processor. A fixed priority table picks the winning source. Software can move any one source to the top of that table. A mode bit chooses how four serial-channel sources are placed in the table. Either they sit together at the top, or they are spread at every eighth entry.

The processor acknowledges with a single-cycle pulse on `iack`. One cycle later the block returns an 8-bit vector. The vector is a 3-bit base field placed above the winner's 5-bit source code. At the same time the block clears the winner's pending bit, unless that source is backed by its own event register. If nothing unmasked is pending, an error vector is returned instead. The response is a valid-only stream with no back-pressure: `vec_valid` is high for exactly one cycle, and the consumer must take `vec_data` in that cycle.

Software uses a plain register port. Address 0 is the pending register, which is cleared by writing ones. Address 1 is the mask. Address 2 is the configuration:

| Config bits | Field |
|---|---|
| [4:0] | promoted source |
| [7:5] | vector base |
| [8] | spread mode |

Reads are combinational. Address 3 reads as zero.

Top module: `vic_top`

## Requirements
- R1: A rising edge on `src_req[i]` (i = 1..31) for a normal source sets pending bit i at the next clock edge. Bit 0 is reserved: it never sets and always reads 0.
- R2: A write to address 0 clears every pending bit written with 1. Bits written with 0 keep their value, and a write never sets a pending bit.
- R3: Reset clears pending and mask, sets the promoted-source field to 31, sets the base to 0 and clears spread mode. Config therefore reads 0x1F.
- R4: `irq` is high exactly when some pending bit is also set in the mask register (address 1). Only such bits take part in arbitration.
- R5: With spread = 0, the priority order from highest to lowest is: serial sources 30, 29, 28, 27, then source 31, then sources 26 down to 1.
- R6: With spread = 1, the serial sources 30, 29, 28 and 27 occupy table entries 0, 8, 16 and 24. The other sources keep their order (31, 26..1) in the remaining entries. Pending bit positions are the same in both modes.
- R7: When the promoted-source field is not 31, that source wins over every other unmasked source whenever it is pending. The value 31 leaves the table unchanged.
- R8: One cycle after `iack`, `vec_valid` is high for one cycle and `vec_data` = {base[2:0], winner code[4:0]}.
- R9: Until the config register has been written after reset, every non-error acknowledge returns 8'h0F.
- R10: An acknowledge clears the winner's pending bit, provided the winner is a normal source.
- R11: Sources 27..30 are event-backed. Their pending bit follows `src_req` one cycle later. Neither an acknowledge nor a software write clears it.
- R12: If `iack` arrives while no unmasked source is pending, `vec_err` is high with `vec_valid`, `vec_data` = {base, 5'b00000}, and the pending register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Interrupt requests from the sources |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Combined masked interrupt request |
| iack | input | 1 | Acknowledge pulse |
| vec_valid | output | 1 | Vector response valid, one cycle |
| vec_data | output | 8 | Vector number |
| vec_err | output | 1 | Response is the error vector |

## Verification
The assertions assume that `iack` is a single-cycle pulse. They also assume that event-backed requests are stable levels, and that `src_req` is low while reset is held. The bench drives every input on the falling clock edge. It raises normal requests as one-cycle pulses and holds event-backed requests as levels across whole scenarios. It never issues a software clear in the same cycle as a request edge or an acknowledge, so every expected pending value has a single cause.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC    = 32;
  localparam int CW      = $clog2(NSRC);
  localparam int NENT    = NSRC - 1;          // table entries, code 0 reserved
  localparam int NSER    = 4;
  localparam int SPACING = 8;
  localparam int BW      = 3;
  localparam int VW      = BW + CW;
  localparam logic [CW-1:0] HP_NONE = CW'(NSRC - 1);
  // serial codes, entry order 0..3
  localparam logic [NSER*CW-1:0] SER_CODES = {5'd27, 5'd28, 5'd29, 5'd30};
  localparam logic [NSRC-1:0] EVT_SRC = 32'h7800_0000;
  localparam logic [NSRC-1:0] RSV_SRC = 32'h0000_0001;

  // priority-table entry -> source code
  function automatic logic [CW-1:0] tab_code(input logic spread, input int e);
    int k;
    int nser;
    if (!spread) begin
      if (e < NSER) return SER_CODES[e*CW +: CW];
      k = e - NSER;
    end else begin
      if ((e % SPACING) == 0 && (e / SPACING) < NSER)
        return SER_CODES[(e/SPACING)*CW +: CW];
      nser = e / SPACING + 1;
      if (nser > NSER) nser = NSER;
      k = e - nser;
    end
    if (k == 0) return CW'(NSRC - 1);
    return CW'(NSRC - 1 - NSER - k);
  endfunction
endpackage

// File: rtl/vic_pending.sv
module vic_pending
  import vic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] ack_clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] nxt;

  assign rise = req & ~req_q;

  always_comb begin
    nxt = (pend & ~(sw_clr | ack_clr)) | rise;  // a new edge wins over a clear
    nxt = (nxt & ~EVT_SRC) | (req & EVT_SRC);
    nxt = nxt & ~RSV_SRC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req;
      pend  <= nxt;
    end
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
(
  input  logic [NSRC-1:0] act,
  input  logic            spread,
  input  logic [CW-1:0]   hp,
  output logic            any,
  output logic [CW-1:0]   win
);
  always_comb begin
    any = |act;
    win = '0;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (act[tab_code(spread, e)]) win = tab_code(spread, e);
    end
    if (hp != HP_NONE && act[hp]) win = hp;
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq,
  input  logic            iack,
  output logic            vec_valid,
  output logic [VW-1:0]   vec_data,
  output logic            vec_err
);
  localparam logic [VW-1:0] VEC_UNINIT = 8'h0F;

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] mask_q;
  logic [CW-1:0]   hp_q;
  logic [BW-1:0]   vb_q;
  logic            vb_set;
  logic            spread_q;
  logic [NSRC-1:0] sw_clr;
  logic [NSRC-1:0] ack_clr;
  logic [NSRC-1:0] act;
  logic            any;
  logic [CW-1:0]   win;

  assign act    = pend_q & mask_q;
  assign irq    = |act;
  assign sw_clr = (reg_wr && reg_addr == 2'd0) ? reg_wdata : '0;

  always_comb begin
    ack_clr = '0;
    if (iack && any) ack_clr[win] = 1'b1;
  end

  vic_pending pend_i (
    .clk(clk), .rst_n(rst_n), .req(src_req),
    .sw_clr(sw_clr), .ack_clr(ack_clr), .pend(pend_q)
  );

  vic_arbiter arb_i (
    .act(act), .spread(spread_q), .hp(hp_q), .any(any), .win(win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      hp_q     <= HP_NONE;
      vb_q     <= '0;
      vb_set   <= 1'b0;
      spread_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd1) mask_q <= reg_wdata;
      if (reg_addr == 2'd2) begin
        hp_q     <= reg_wdata[CW-1:0];
        vb_q     <= reg_wdata[CW +: BW];
        spread_q <= reg_wdata[CW+BW];
        vb_set   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_err   <= 1'b0;
      vec_data  <= '0;
    end else begin
      vec_valid <= iack;
      vec_err   <= iack && !any;
      if (iack) begin
        if (!any)        vec_data <= {vb_q, {CW{1'b0}}};
        else if (vb_set) vec_data <= {vb_q, win};
        else             vec_data <= VEC_UNINIT;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = pend_q;
      2'd1:    reg_rdata = mask_q;
      2'd2:    reg_rdata = NSRC'({spread_q, vb_q, hp_q});
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vic_chk.sv
module vic_chk
  import vic_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] pend,
  input logic            irq,
  input logic            iack,
  input logic            vec_valid,
  input logic            vec_err,
  input logic [VW-1:0]   vec_data,
  input logic            base_set
);
  // R8
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> vec_valid);
  // R8
  no_spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |=> !vec_valid);
  // R12
  err_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !irq) |=> (vec_valid && vec_err));
  // R1
  set_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((pend & ~$past(pend)) & ~EVT_SRC & ~$past(src_req)) == '0));
  // R11
  evt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((pend ^ $past(src_req)) & EVT_SRC) == '0));
  // R9
  uninit_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_err && !base_set) |-> (vec_data == 8'h0F));
endmodule

bind vic_top vic_chk chk_i (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .pend(pend_q), .irq(irq),
  .iack(iack), .vec_valid(vec_valid), .vec_err(vec_err), .vec_data(vec_data),
  .base_set(vb_set)
);

// File: tb/vic_top_tb_top.sv
`timescale 1ns/1ps
module vic_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        iack = 1'b0;
  logic        vec_valid;
  logic [7:0]  vec_data;
  logic        vec_err;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vic_top dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .iack(iack), .vec_valid(vec_valid), .vec_data(vec_data), .vec_err(vec_err)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] m);
    src_req = src_req | m;
    @(negedge clk);
    src_req = src_req & ~m;
  endtask

  task automatic level(input int b, input logic v);
    src_req[b] = v;
    @(negedge clk);
  endtask

  task automatic ack(output logic [7:0] v, output logic e, output logic ok);
    iack = 1'b1;
    @(negedge clk);
    iack = 1'b0;
    v = vec_data; e = vec_err; ok = vec_valid;
  endtask

  task automatic ack_chk(input string rq, input logic [7:0] exp_v, input logic exp_e);
    logic [7:0] v; logic e; logic ok;
    ack(v, e, ok);
    chk(rq, {23'b0, ok, e, v}, {23'b0, 1'b1, exp_e, exp_v});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); chk("R3 pending", d, 32'h0);
    rd(1, d); chk("R3 mask", d, 32'h0);
    rd(2, d); chk("R3 config", d, 32'h1F);
    chk("R3 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] d;
    pulse(32'h0000_1020);
    rd(0, d); chk("R1 set", d, 32'h0000_1020);
    pulse(32'h1);
    rd(0, d); chk("R1 bit0 reserved", d, 32'h0000_1020);
    chk("R4 irq masked", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(0, 32'h0000_0021);
    rd(0, d); chk("R2 clear ones", d, 32'h0000_1000);
    wr(0, 32'h0000_0008);
    rd(0, d); chk("R2 no set", d, 32'h0000_1000);
    wr(0, 32'h0000_1000);
    rd(0, d); chk("R2 clear last", d, 32'h0);
  endtask

  task automatic t_mask();
    wr(1, 32'hFFFF_FFFE);
    pulse(32'h20);
    chk("R4 irq on", {31'b0, irq}, 32'h1);
    wr(1, 32'h0);
    chk("R4 irq off", {31'b0, irq}, 32'h0);
    wr(1, 32'hFFFF_FFFF);
  endtask

  task automatic t_uninit();
    logic [31:0] d;
    ack_chk("R9 uninit vector", 8'h0F, 1'b0);
    rd(0, d); chk("R10 ack clears", d, 32'h0);
  endtask

  task automatic t_grouped();
    logic [31:0] d;
    wr(2, 32'h7F);
    pulse(32'h8400_0020);
    ack_chk("R5 src31 first", 8'h7F, 1'b0);
    ack_chk("R8 src26 vector", 8'h7A, 1'b0);
    ack_chk("R8 src5 vector", 8'h65, 1'b0);
    rd(0, d); chk("R10 all cleared", d, 32'h0);
    level(27, 1'b1);
    pulse(32'h8000_0000);
    ack_chk("R5 serial above 31", 8'h7B, 1'b0);
    rd(0, d); chk("R11 ack keeps evt", d, 32'h8800_0000);
    wr(0, 32'h0800_0000);
    rd(0, d); chk("R11 write keeps evt", d, 32'h8800_0000);
    level(27, 1'b0);
    rd(0, d); chk("R11 follows req", d, 32'h8000_0000);
    ack_chk("R5 src31 after", 8'h7F, 1'b0);
  endtask

  task automatic t_spread();
    logic [31:0] d;
    wr(2, 32'h17F);
    level(27, 1'b1);
    pulse(32'h8000_0000);
    ack_chk("R6 31 above serial27", 8'h7F, 1'b0);
    level(28, 1'b1);
    pulse(32'h0000_4000);
    ack_chk("R6 entry15 above 16", 8'h6E, 1'b0);
    ack_chk("R6 28 above 27", 8'h7C, 1'b0);
    rd(0, d); chk("R6 bit positions", d, 32'h1800_0000);
    src_req[27] = 1'b0;
    level(28, 1'b0);
    rd(0, d); chk("R11 evt dropped", d, 32'h0);
  endtask

  task automatic t_promote();
    wr(2, 32'h62);
    pulse(32'h8000_0004);
    ack_chk("R7 promoted src2", 8'h62, 1'b0);
    wr(2, 32'h7F);
    pulse(32'h0000_0004);
    ack_chk("R7 none promoted", 8'h7F, 1'b0);
    ack_chk("R7 src2 next", 8'h62, 1'b0);
  endtask

  task automatic t_error();
    logic [31:0] d;
    ack_chk("R12 idle error", 8'h60, 1'b1);
    pulse(32'h0000_0200);
    wr(1, 32'h0);
    ack_chk("R12 masked error", 8'h60, 1'b1);
    rd(0, d); chk("R12 pending kept", d, 32'h0000_0200);
    wr(1, 32'hFFFF_FFFF);
    wr(0, 32'h0000_0200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set();
    t_w1c();
    t_mask();
    t_uninit();
    t_grouped();
    t_spread();
    t_promote();
    t_error();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule